// File: doc/BRIEF.md
# Instruction Class Exception Resolver

This block sits behind an instruction pre-decoder and turns each instruction into exactly one outcome. The instruction either executes or raises one interrupt type. The pre-decoder sends a set of class flags with each instruction:

- floating-point class
- valid only for 64-bit execution
- allocated (application-specific) class
- one of the defined operations this core leaves out (the multiprocessor TLB invalidate-by-address and the indirect coprocessor-ID read)
- recognized
- supported

Alongside the flags, the block samples two machine-state enables, one for floating-point processing and one for allocated processing, and a strap that says whether a floating-point coprocessor is attached.

The block applies a fixed precedence. It checks first whether the instruction is recognized, then whether its class is enabled, then whether it is supported. The floating-point class and the allocated class raise different "unavailable" interrupts. A missing coprocessor makes every floating-point instruction illegal.

The result is held in a single output register with a valid/ready handshake. Because input ready passes back combinationally, a stream moves at one instruction per cycle while the consumer keeps ready high.

Top module: `insn_outcome_resolver`

## Requirements
- R1: While synchronous active-high reset `rst` is high, `out_valid` is cleared. After reset, `in_ready` is 1.
- R2: An instruction flagged 64-bit-only produces outcome code 1 (illegal). This holds whatever the enables, the coprocessor strap or the other flags are.
- R3: An instruction flagged as one of the omitted defined operations (TLB invalidate-by-address, indirect coprocessor-ID read) produces code 1 (illegal).
- R4: With `fp_cop_present` low, any instruction flagged floating-point produces code 1 (illegal).
- R5: A recognized floating-point instruction produces code 3 (floating-point unavailable) when the coprocessor is present, `fp_enable` is low and no illegal condition applies.
- R6: A recognized instruction whose class is enabled but which is flagged not supported produces code 2 (unimplemented).
- R7: Any instruction that is not recognized, including an allocated-class one, produces code 1 (illegal).
- R8: A recognized allocated instruction with `alloc_enable` low produces code 4 (auxiliary unavailable), never code 3, unless a floating-point condition applies.
- R9: A recognized, supported instruction whose class is enabled produces code 0 (execute).
- R10: Outcomes have this precedence: illegal (1), then floating-point unavailable (3), then auxiliary unavailable (4), then unimplemented (2), then execute (0). The order holds even when the flags conflict. Codes above 4 never appear.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_code` hold. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R12: An instruction accepted on a clock edge (`in_valid` and `in_ready` high) appears on `out_code` with `out_valid` high right after that edge. `out_valid` falls after a taken output with no new input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction flags are valid |
| in_ready | output | 1 | Block can accept an instruction |
| cls_fp | input | 1 | Floating-point class |
| cls_wide64 | input | 1 | Defined only for 64-bit execution |
| cls_alloc | input | 1 | Allocated (application-specific) class |
| cls_omitted | input | 1 | Defined operation this core does not provide |
| cls_recog | input | 1 | Recognized by the implementation |
| cls_supported | input | 1 | Supported by the implementation |
| fp_enable | input | 1 | Floating-point processing enabled |
| alloc_enable | input | 1 | Allocated-instruction processing enabled |
| fp_cop_present | input | 1 | Floating-point coprocessor attached |
| out_valid | output | 1 | Outcome register holds a result |
| out_ready | input | 1 | Consumer takes the outcome |
| out_code | output | CODE_W | Outcome: 0 execute, 1 illegal, 2 unimplemented, 3 FP unavailable, 4 aux unavailable |

## Verification
The assertions assume that the class flags, enables and strap are stable and known whenever `in_valid` is high. They also assume that `out_ready` is never X after reset.

The bench changes inputs only on falling edges, and it draws every flag from biased `$urandom` values so that none is ever X. Because the flags are drawn independently, conflicting combinations also occur, such as floating-point and allocated set together, or not recognized but marked supported. This is how the precedence rules are exercised.

// File: rtl/insn_res_pkg.sv
package insn_res_pkg;

   typedef enum logic [2:0] {
      OC_EXEC     = 3'd0,
      OC_ILLEGAL  = 3'd1,
      OC_UNIMPL   = 3'd2,
      OC_FP_UNAV  = 3'd3,
      OC_AUX_UNAV = 3'd4
   } outcome_e;

   typedef struct packed {
      logic fp;
      logic wide64;
      logic alloc;
      logic omitted;
      logic recog;
      logic supported;
   } cls_flags_t;

   typedef struct packed {
      logic fp_en;
      logic alloc_en;
      logic cop;
   } mach_state_t;

endpackage

// File: rtl/insn_res_classify.sv
module insn_res_classify
   import insn_res_pkg::*;
#(
   parameter bit HAS_ALLOC_CLASS = 1'b1
) (
   input  cls_flags_t  flags,
   input  mach_state_t mstate,
   output outcome_e    code
);

   logic alloc_known;
   logic is_illegal;
   logic fp_unav;
   logic aux_unav;

   generate
      if (HAS_ALLOC_CLASS) begin : g_alloc_on
         assign alloc_known = flags.recog;
      end else begin : g_alloc_off
         assign alloc_known = 1'b0;
      end
   endgenerate

   always_comb begin
      is_illegal = flags.wide64 | flags.omitted | ~flags.recog
                 | (flags.fp & ~mstate.cop)
                 | (flags.alloc & ~alloc_known);
      fp_unav    = flags.fp & ~mstate.fp_en;
      aux_unav   = flags.alloc & ~mstate.alloc_en;
      if (is_illegal)            code = OC_ILLEGAL;
      else if (fp_unav)          code = OC_FP_UNAV;
      else if (aux_unav)         code = OC_AUX_UNAV;
      else if (!flags.supported) code = OC_UNIMPL;
      else                       code = OC_EXEC;
   end

endmodule

// File: rtl/insn_res_outreg.sv
module insn_res_outreg #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);

   logic take;

   assign up_ready = ~dn_valid | dn_ready;
   assign take     = up_valid & up_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         dn_valid <= 1'b0;
      end else if (take) begin
         dn_valid <= 1'b1;
      end else if (dn_ready) begin
         dn_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         dn_data <= up_data;
      end
   end

endmodule

// File: rtl/insn_outcome_resolver.sv
module insn_outcome_resolver
   import insn_res_pkg::*;
#(
   parameter int CODE_W          = 3,
   parameter bit HAS_ALLOC_CLASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              cls_fp,
   input  logic              cls_wide64,
   input  logic              cls_alloc,
   input  logic              cls_omitted,
   input  logic              cls_recog,
   input  logic              cls_supported,
   input  logic              fp_enable,
   input  logic              alloc_enable,
   input  logic              fp_cop_present,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [CODE_W-1:0] out_code
);

   localparam int ENUM_W = $bits(outcome_e);

   generate
      if (CODE_W < ENUM_W) begin : g_bad_width
         $error("CODE_W must hold the outcome encoding");
      end
   endgenerate

   cls_flags_t  flags;
   mach_state_t mstate;
   outcome_e    code;
   logic [CODE_W-1:0] code_ext;

   assign flags  = '{fp: cls_fp, wide64: cls_wide64, alloc: cls_alloc,
                     omitted: cls_omitted, recog: cls_recog,
                     supported: cls_supported};
   assign mstate = '{fp_en: fp_enable, alloc_en: alloc_enable,
                     cop: fp_cop_present};

   insn_res_classify #(.HAS_ALLOC_CLASS(HAS_ALLOC_CLASS)) u_classify (
      .flags  (flags),
      .mstate (mstate),
      .code   (code)
   );

   generate
      if (CODE_W > ENUM_W) begin : g_pad
         assign code_ext = {{(CODE_W-ENUM_W){1'b0}}, code};
      end else begin : g_exact
         assign code_ext = code[CODE_W-1:0];
      end
   endgenerate

   insn_res_outreg #(.W(CODE_W)) u_outreg (
      .clk      (clk),
      .rst      (rst),
      .up_valid (in_valid),
      .up_ready (in_ready),
      .up_data  (code_ext),
      .dn_valid (out_valid),
      .dn_ready (out_ready),
      .dn_data  (out_code)
   );

endmodule

// File: rtl/insn_outcome_resolver_chk.sv
module insn_outcome_resolver_chk #(
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              cls_fp,
   input logic              cls_wide64,
   input logic              cls_alloc,
   input logic              cls_omitted,
   input logic              cls_recog,
   input logic              fp_enable,
   input logic              alloc_enable,
   input logic              fp_cop_present,
   input logic              out_valid,
   input logic              out_ready,
   input logic [CODE_W-1:0] out_code
);

   logic acc;
   logic clean;
   assign acc   = in_valid && in_ready;
   assign clean = cls_recog && !cls_wide64 && !cls_omitted && fp_cop_present;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      $past(rst) |-> !out_valid);  // R1

   AST_WIDE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
      acc && cls_wide64 |=> out_valid && out_code == CODE_W'(1));  // R2

   AST_OMITTED_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
      acc && cls_omitted |=> out_valid && out_code == CODE_W'(1));  // R3

   AST_NOCOP_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
      acc && cls_fp && !fp_cop_present |=> out_code == CODE_W'(1));  // R4

   AST_FP_UNAV: assert property (@(posedge clk) disable iff (rst)
      acc && clean && cls_fp && !fp_enable |=> out_code == CODE_W'(3));  // R5

   AST_UNRECOG_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
      acc && !cls_recog |=> out_code == CODE_W'(1));  // R7

   AST_AUX_UNAV: assert property (@(posedge clk) disable iff (rst)
      acc && clean && !cls_fp && cls_alloc && !alloc_enable
      |=> out_code == CODE_W'(4));  // R8

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_code <= CODE_W'(4));  // R10

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_code));  // R11

   AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
      acc |=> out_valid);  // R12

   AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && !in_valid |=> !out_valid);  // R12

endmodule

bind insn_outcome_resolver insn_outcome_resolver_chk #(.CODE_W(CODE_W)) u_chk (
   .clk            (clk),
   .rst            (rst),
   .in_valid       (in_valid),
   .in_ready       (in_ready),
   .cls_fp         (cls_fp),
   .cls_wide64     (cls_wide64),
   .cls_alloc      (cls_alloc),
   .cls_omitted    (cls_omitted),
   .cls_recog      (cls_recog),
   .fp_enable      (fp_enable),
   .alloc_enable   (alloc_enable),
   .fp_cop_present (fp_cop_present),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_code       (out_code)
);

// File: tb/insn_outcome_resolver_bench.sv
module insn_outcome_resolver_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0, out_ready = 1'b0;
   logic f_fp = 0, f_w64 = 0, f_al = 0, f_om = 0, f_rc = 1, f_sp = 1;
   logic fe = 1, ae = 1, cop = 1;
   logic in_ready, out_valid;
   logic [2:0] out_code;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic       m_valid = 1'b0;
   logic [2:0] m_code  = 3'd0;

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_outcome_resolver u_insn_outcome_resolver (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .cls_fp(f_fp), .cls_wide64(f_w64), .cls_alloc(f_al),
      .cls_omitted(f_om), .cls_recog(f_rc), .cls_supported(f_sp),
      .fp_enable(fe), .alloc_enable(ae), .fp_cop_present(cop),
      .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
   );

   function automatic logic [2:0] ref_code(logic fp, w64, al, om, rc, sp,
                                           logic e_fp, e_al, c);
      if (w64 || om || !rc || (fp && !c)) return 3'd1;
      if (fp && !e_fp)                    return 3'd3;
      if (al && !e_al)                    return 3'd4;
      if (!sp)                            return 3'd2;
      return 3'd0;
   endfunction

   function automatic string ref_tag(logic fp, w64, al, om, rc, sp,
                                     logic e_fp, e_al, c);
      if (w64)          return "R2";
      if (om)           return "R3";
      if (fp && !c)     return "R4";
      if (!rc)          return "R7";
      if (fp && !e_fp)  return "R5";
      if (al && !e_al)  return "R8";
      if (!sp)          return "R6";
      return "R9";
   endfunction

   string   last_tag = "R9";

   task automatic check(string req, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: model the edge from the inputs that were applied, then compare.
   task automatic tick();
      logic rdy;
      @(negedge clk);
      rdy = !m_valid || out_ready;
      if (in_valid && rdy) begin
         m_valid = 1'b1;
         m_code  = ref_code(f_fp, f_w64, f_al, f_om, f_rc, f_sp, fe, ae, cop);
         last_tag = ref_tag(f_fp, f_w64, f_al, f_om, f_rc, f_sp, fe, ae, cop);
      end else if (out_ready) begin
         m_valid = 1'b0;
      end
      check("R12 out_valid", {2'b0, out_valid}, {2'b0, m_valid});
      check("R11 in_ready", {2'b0, in_ready}, {2'b0, (!m_valid || out_ready)});
      if (m_valid) check({last_tag, "/R10 out_code"}, out_code, m_code);
   endtask

   task automatic drive(logic v, r, fp, w64, al, om, rc, sp, e_fp, e_al, c);
      in_valid = v; out_ready = r;
      f_fp = fp; f_w64 = w64; f_al = al; f_om = om; f_rc = rc; f_sp = sp;
      fe = e_fp; ae = e_al; cop = c;
      tick();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", {2'b0, out_valid}, 3'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 in_ready after reset", {2'b0, in_ready}, 3'd1);
      check("R1 out_valid after reset", {2'b0, out_valid}, 3'd0);

      // Directed: v r fp w64 al om rc sp fe ae cop
      drive(1,1, 0,1,0,0,1,1, 1,1,1);  // R2 wide, all enabled
      drive(1,1, 1,1,1,0,1,1, 0,0,0);  // R2 wide with every other condition
      drive(1,1, 0,0,0,1,1,1, 1,1,1);  // R3 omitted op
      drive(1,1, 1,0,0,0,1,1, 1,1,0);  // R4 fp without coprocessor
      drive(1,1, 1,0,0,0,1,1, 0,1,1);  // R5 fp disabled
      drive(1,1, 1,0,0,0,1,0, 1,1,1);  // R6 fp unsupported
      drive(1,1, 0,0,1,0,1,0, 1,1,1);  // R6 allocated unsupported
      drive(1,1, 0,0,1,0,0,1, 1,1,1);  // R7 allocated unrecognized
      drive(1,1, 0,0,1,0,1,1, 1,0,1);  // R8 allocated disabled
      drive(1,1, 1,0,1,0,1,0, 0,0,1);  // R10 fp unav beats aux unav and unimpl
      drive(1,1, 0,0,1,0,1,0, 1,0,1);  // R10 aux unav beats unimpl
      drive(1,1, 0,0,1,0,1,1, 1,1,1);  // R9 allocated executes
      drive(1,1, 0,0,0,0,1,1, 0,0,0);  // R9 plain instruction, no enables
      // R11 stall: hold with new inputs offered
      drive(1,0, 0,0,0,0,1,1, 1,1,1);
      drive(1,0, 0,1,0,0,1,1, 1,1,1);
      drive(1,0, 1,0,0,0,1,1, 0,1,1);
      drive(0,1, 0,0,0,0,1,1, 1,1,1);  // R12 drain
      drive(0,1, 0,0,0,0,1,1, 1,1,1);

      for (int i = 0; i < N_RANDOM; i++) begin
         drive(($urandom % 4) != 0, ($urandom % 10) < 7,
               ($urandom % 10) < 4, ($urandom % 10) == 0,
               ($urandom % 10) < 3, ($urandom % 10) == 0,
               ($urandom % 100) < 85, ($urandom % 4) != 0,
               ($urandom % 10) < 6, ($urandom % 10) < 6,
               ($urandom % 10) < 7);
      end
      drive(0,1, 0,0,0,0,1,1, 1,1,1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule